// File: doc/BRIEF.md
# Fetch Target Queue with Prefetch Lookahead

This block buffers predicted fetch-block start addresses between a branch predictor and a single-ported instruction cache. The predictor may hand over up to `PUSH_W` addresses in one cycle. The cache takes the oldest address, at most one per cycle. While the cache is stalled on a miss, the head stays where it is and the predictor can keep filling the free entries. This lets prediction run ahead of fetch.

The block reports how many addresses it holds and how many slots are free. The predictor uses the free count to size its pushes. A push that does not fit is refused as a whole. A second read path, the lookahead port, walks the entries behind the head. It offers each one once as a prefetch candidate over a ready/valid handshake. A candidate equal to the last address issued is dropped. A flush, raised on a branch misprediction, empties everything in one cycle.

`DEPTH` must be a power of two. Lane 0 of the push bus is the oldest address of a push.

Top module: `fetch_target_queue`

## Requirements
- R1: After reset, `occupancy` is 0, `free_slots` equals `DEPTH`, and `head_valid` and `pf_valid` are low.
- R2: A push of `push_num` = N addresses, with 1 <= N <= `PUSH_W`, stores the addresses in prediction order. Lane i sits in bits [i*ADDR_W +: ADDR_W], and lane 0 is the oldest. The order is preserved across pointer wrap-around, and `occupancy` rises by N one cycle later.
- R3: A push with N greater than `free_slots` is refused as a whole: `push_accept` is low, and neither occupancy nor contents change. `occupancy` never exceeds `DEPTH`.
- R4: `head_valid` is high exactly when the queue holds an address, and `head_addr` is then the oldest address. With `head_take` high, one address leaves per cycle.
- R5: While `head_take` is low (a cache miss), `head_addr` and `head_valid` hold, and pushes keep being accepted while space remains.
- R6: A push of N and a pop in the same cycle change `occupancy` by N-1.
- R7: When the queue is empty, a pushed address is not visible at the head in the cycle it is pushed. A `head_take` in that cycle removes nothing, and the address appears at the head on the next cycle.
- R8: `flush` empties the queue in one cycle and resets the lookahead. It takes priority over a push and a pop in the same cycle, and `push_accept` is low during it.
- R9: The lookahead port offers only entries behind the head, oldest first. Each entry is issued once, on a cycle with `pf_valid` and `pf_ready` both high.
- R10: A lookahead candidate equal to the last issued prefetch address is skipped without being offered.
- R11: `free_slots` always equals `DEPTH` minus `occupancy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Misprediction flush; empties the queue |
| push_num | input | $clog2(PUSH_W+1) | Number of addresses offered this cycle (0 = none) |
| push_addr | input | PUSH_W*ADDR_W | Pushed addresses, lane 0 oldest |
| push_accept | output | 1 | The offered push fits and is taken |
| head_valid | output | 1 | Head address present |
| head_addr | output | ADDR_W | Oldest queued fetch address |
| head_take | input | 1 | Cache consumes the head this cycle |
| occupancy | output | $clog2(DEPTH+1) | Number of stored addresses |
| free_slots | output | $clog2(DEPTH+1) | Number of free entries |
| pf_valid | output | 1 | Prefetch candidate offered |
| pf_addr | output | ADDR_W | Prefetch candidate address |
| pf_ready | input | 1 | Prefetch consumer accepts the candidate |

## Verification
`push_accept` and the prefetch offer are combinational from the current state and inputs, so they are due in the same cycle as the stimulus. Occupancy, free slots and head contents change one clock edge after a push, pop or flush. Inputs are therefore driven one time unit after a rising edge. Same-cycle outputs are read before the next edge, and registered effects are read one time unit after that edge. Prefetch traffic is collected per cycle before the edge that completes each handshake, and then compared as an ordered list against a queue model kept in the bench.

// File: rtl/ftq_pkg.sv
package ftq_pkg;

    // Action chosen by the lookahead walker for the current candidate
    typedef enum logic [1:0] {
        LA_IDLE  = 2'd0,   // nothing behind the head left to scan
        LA_OFFER = 2'd1,   // candidate offered on the prefetch port
        LA_SKIP  = 2'd2    // candidate repeats last issue, step over it
    } la_act_e;

endpackage

// File: rtl/ftq_store.sv
module ftq_store #(
    parameter int DEPTH  = 16,
    parameter int PUSH_W = 2,
    parameter int ADDR_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int NUM_W = $clog2(PUSH_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [NUM_W-1:0]         push_num,
    input  logic [PUSH_W*ADDR_W-1:0] push_addr,
    output logic                     push_accept,
    input  logic                     pop_req,
    output logic                     pop_fire,
    output logic                     head_valid,
    output logic [ADDR_W-1:0]        head_addr,
    output logic [CNT_W-1:0]         occupancy,
    output logic [CNT_W-1:0]         free_slots,
    input  logic [CNT_W-1:0]         la_off,
    output logic [ADDR_W-1:0]        la_addr
);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] count;
    } store_st_t;

    store_st_t         st_d, st_q;
    logic [ADDR_W-1:0] mem_d [DEPTH];
    logic [ADDR_W-1:0] mem_q [DEPTH];
    logic [ADDR_W-1:0] lane_addr [PUSH_W];
    logic [CNT_W-1:0]  free_w;
    logic              push_ok;
    logic              pop_ok;

    for (genvar g = 0; g < PUSH_W; g++) begin : g_lane
        assign lane_addr[g] = push_addr[g*ADDR_W +: ADDR_W];
    end

    always_comb begin
        free_w  = CNT_W'(DEPTH) - st_q.count;
        push_ok = !flush && (push_num != '0) && (int'(push_num) <= PUSH_W)
                  && (CNT_W'(push_num) <= free_w);
        pop_ok  = !flush && pop_req && (st_q.count != '0);
        st_d    = st_q;
        mem_d   = mem_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok) begin
                for (int i = 0; i < PUSH_W; i++) begin
                    if (i < int'(push_num)) begin
                        mem_d[PTR_W'(st_q.wr + PTR_W'(i))] = lane_addr[i];
                    end
                end
                st_d.wr = st_q.wr + PTR_W'(push_num);
            end
            if (pop_ok) begin
                st_d.rd = st_q.rd + PTR_W'(1);
            end
            st_d.count = st_q.count
                         + (push_ok ? CNT_W'(push_num) : CNT_W'(0))
                         - (pop_ok  ? CNT_W'(1)        : CNT_W'(0));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    assign push_accept = push_ok;
    assign pop_fire    = pop_ok;
    assign head_valid  = (st_q.count != '0);
    assign head_addr   = mem_q[st_q.rd];
    assign occupancy   = st_q.count;
    assign free_slots  = free_w;
    assign la_addr     = mem_q[PTR_W'(st_q.rd + PTR_W'(la_off))];

    // R3: never more entries than storage
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH));

    // R4: at most one address leaves per cycle
    a_r4_one_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (occupancy + CNT_W'(1) >= $past(occupancy)));

    // R8: flush leaves an empty queue
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occupancy == '0) && !head_valid);

    // R5: head held while the cache does not take it
    a_r5_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !pop_req && !flush) |=> head_valid && $stable(head_addr));

endmodule

// File: rtl/ftq_lookahead.sv
module ftq_lookahead
    import ftq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [CNT_W-1:0]  occupancy,
    input  logic              pop_done,
    output logic [CNT_W-1:0]  la_off,
    input  logic [ADDR_W-1:0] la_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr,
    input  logic              pf_ready
);

    typedef struct packed {
        logic [CNT_W-1:0]  off;       // distance of next candidate from head
        logic [ADDR_W-1:0] last_addr; // last prefetch issued
        logic              last_vld;
    } la_st_t;

    la_st_t           st_d, st_q;
    la_act_e          act;
    logic             cand;
    logic             dup;
    logic             adv;
    logic [CNT_W-1:0] nxt_off;

    always_comb begin
        cand = !flush && (st_q.off < occupancy);
        dup  = st_q.last_vld && (la_addr == st_q.last_addr);
        if (!cand) begin
            act = LA_IDLE;
        end else if (dup) begin
            act = LA_SKIP;
        end else begin
            act = LA_OFFER;
        end
        adv     = (act == LA_SKIP) || ((act == LA_OFFER) && pf_ready);
        nxt_off = st_q.off + (adv ? CNT_W'(1) : CNT_W'(0))
                           - (pop_done ? CNT_W'(1) : CNT_W'(0));
        if (nxt_off == '0) begin
            nxt_off = CNT_W'(1);
        end
        st_d = st_q;
        if (flush) begin
            st_d.off      = CNT_W'(1);
            st_d.last_vld = 1'b0;
        end else begin
            st_d.off = nxt_off;
            if ((act == LA_OFFER) && pf_ready) begin
                st_d.last_addr = la_addr;
                st_d.last_vld  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.off  <= CNT_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign la_off   = st_q.off;
    assign pf_valid = (act == LA_OFFER);
    assign pf_addr  = la_addr;

    // R9: only entries behind the head are offered
    a_r9_beyond_head: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (la_off >= CNT_W'(1)) && (la_off < occupancy));

    // R10: two consecutive issues never carry the same address
    a_r10_no_repeat: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (pf_valid && pf_ready) |=> !(pf_valid && pf_ready && (pf_addr == $past(pf_addr))));

endmodule

// File: rtl/fetch_target_queue.sv
module fetch_target_queue #(
    parameter int DEPTH  = 16,
    parameter int PUSH_W = 2,
    parameter int ADDR_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int NUM_W = $clog2(PUSH_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [NUM_W-1:0]         push_num,
    input  logic [PUSH_W*ADDR_W-1:0] push_addr,
    output logic                     push_accept,
    output logic                     head_valid,
    output logic [ADDR_W-1:0]        head_addr,
    input  logic                     head_take,
    output logic [CNT_W-1:0]         occupancy,
    output logic [CNT_W-1:0]         free_slots,
    output logic                     pf_valid,
    output logic [ADDR_W-1:0]        pf_addr,
    input  logic                     pf_ready
);

    logic [CNT_W-1:0]  la_off;
    logic [ADDR_W-1:0] la_addr;
    logic              pop_fire;

    ftq_store #(.DEPTH(DEPTH), .PUSH_W(PUSH_W), .ADDR_W(ADDR_W)) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .push_num    (push_num),
        .push_addr   (push_addr),
        .push_accept (push_accept),
        .pop_req     (head_take),
        .pop_fire    (pop_fire),
        .head_valid  (head_valid),
        .head_addr   (head_addr),
        .occupancy   (occupancy),
        .free_slots  (free_slots),
        .la_off      (la_off),
        .la_addr     (la_addr)
    );

    ftq_lookahead #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_lookahead (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .occupancy (occupancy),
        .pop_done  (pop_fire),
        .la_off    (la_off),
        .la_addr   (la_addr),
        .pf_valid  (pf_valid),
        .pf_addr   (pf_addr),
        .pf_ready  (pf_ready)
    );

endmodule

// File: tb/test_fetch_target_queue.sv
module test_fetch_target_queue;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int PUSH_W = 2;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int NUM_W  = $clog2(PUSH_W + 1);

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     flush = 1'b0;
    logic [NUM_W-1:0]         push_num = '0;
    logic [PUSH_W*ADDR_W-1:0] push_addr = '0;
    logic                     push_accept;
    logic                     head_valid;
    logic [ADDR_W-1:0]        head_addr;
    logic                     head_take = 1'b0;
    logic [CNT_W-1:0]         occupancy;
    logic [CNT_W-1:0]         free_slots;
    logic                     pf_valid;
    logic [ADDR_W-1:0]        pf_addr;
    logic                     pf_ready = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] model [$];
    logic [31:0] got [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_target_queue #(.DEPTH(DEPTH), .PUSH_W(PUSH_W), .ADDR_W(ADDR_W)) i_fetch_target_queue (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_num(push_num), .push_addr(push_addr), .push_accept(push_accept),
        .head_valid(head_valid), .head_addr(head_addr), .head_take(head_take),
        .occupancy(occupancy), .free_slots(free_slots),
        .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input int n, input logic [31:0] a0, input logic [31:0] a1, input bit ok);
        push_num  = NUM_W'(n);
        push_addr = {a1, a0};
        #1;
        chk(ok ? "R2 push_accept" : "R3 push_accept", 32'(push_accept), 32'(ok));
        tick();
        push_num = '0;
        if (ok) begin
            model.push_back(a0);
            if (n > 1) model.push_back(a1);
        end
    endtask

    task automatic pop_one(input string req);
        chk(req, 32'(head_valid), 32'd1);
        chk(req, head_addr, model[0]);
        head_take = 1'b1;
        tick();
        head_take = 1'b0;
        void'(model.pop_front());
        chk(req, 32'(occupancy), 32'(model.size()));
    endtask

    task automatic do_flush();
        flush = 1'b1;
        tick();
        flush = 1'b0;
        model.delete();
        chk("R8 occupancy", 32'(occupancy), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 occupancy", 32'(occupancy), 32'd0);
        chk("R1 free_slots", 32'(free_slots), 32'(DEPTH));
        chk("R1 head_valid", 32'(head_valid), 32'd0);
        chk("R1 pf_valid", 32'(pf_valid), 32'd0);
    endtask

    task automatic t_order();
        push(2, 32'h1000, 32'h1040, 1'b1);
        push(1, 32'h2000, 32'h0, 1'b1);
        chk("R2 occupancy", 32'(occupancy), 32'd3);
        chk("R11 free_slots", 32'(free_slots), 32'(DEPTH - 3));
        for (int k = 0; k < 3; k++) pop_one("R4 pop order");
        chk("R4 head_valid empty", 32'(head_valid), 32'd0);
    endtask

    task automatic t_miss();
        push(1, 32'h3000, 32'h0, 1'b1);
        for (int k = 0; k < 4; k++) begin
            push(2, 32'h4000 + 32'(k*128), 32'h4040 + 32'(k*128), 1'b1);
            chk("R5 head held", head_addr, 32'h3000);
            chk("R5 head_valid", 32'(head_valid), 32'd1);
            chk("R5 occupancy", 32'(occupancy), 32'(3 + 2*k));
        end
        do_flush();
    endtask

    task automatic t_full();
        push(2, 32'h5000, 32'h5010, 1'b1);
        pop_one("R4 pre-wrap");
        pop_one("R4 pre-wrap");
        for (int k = 0; k < 7; k++) push(2, 32'h6000 + 32'(k*32), 32'h6010 + 32'(k*32), 1'b1);
        push(1, 32'h6800, 32'h0, 1'b1);
        chk("R3 occupancy 15", 32'(occupancy), 32'd15);
        push(2, 32'hdead0, 32'hdead1, 1'b0);
        chk("R3 refused whole", 32'(occupancy), 32'd15);
        chk("R11 free one", 32'(free_slots), 32'd1);
        push(1, 32'h6900, 32'h0, 1'b1);
        chk("R11 free zero", 32'(free_slots), 32'd0);
        push(1, 32'hbeef0, 32'h0, 1'b0);
        chk("R3 full", 32'(occupancy), 32'(DEPTH));
        for (int k = 0; k < DEPTH; k++) pop_one("R2 wrap order");
    endtask

    task automatic t_push_pop();
        push(2, 32'h7000, 32'h7010, 1'b1);
        push_num  = NUM_W'(2);
        push_addr = {32'h7030, 32'h7020};
        head_take = 1'b1;
        tick();
        push_num  = '0;
        head_take = 1'b0;
        model.push_back(32'h7020);
        model.push_back(32'h7030);
        void'(model.pop_front());
        chk("R6 occupancy", 32'(occupancy), 32'd3);
        chk("R6 head", head_addr, model[0]);
        do_flush();
    endtask

    task automatic t_no_bypass();
        push_num  = NUM_W'(1);
        push_addr = {32'h0, 32'h8000};
        head_take = 1'b1;
        #1;
        chk("R7 no head same cycle", 32'(head_valid), 32'd0);
        tick();
        push_num  = '0;
        head_take = 1'b0;
        chk("R7 head next cycle", 32'(head_valid), 32'd1);
        chk("R7 head addr", head_addr, 32'h8000);
        chk("R7 take ignored", 32'(occupancy), 32'd1);
    endtask

    task automatic t_flush_prio();
        flush     = 1'b1;
        push_num  = NUM_W'(2);
        push_addr = {32'h9010, 32'h9000};
        head_take = 1'b1;
        #1;
        chk("R8 push refused", 32'(push_accept), 32'd0);
        tick();
        flush = 1'b0;
        push_num = '0;
        head_take = 1'b0;
        model.delete();
        chk("R8 empty", 32'(occupancy), 32'd0);
        chk("R8 head_valid", 32'(head_valid), 32'd0);
        chk("R8 pf_valid", 32'(pf_valid), 32'd0);
    endtask

    task automatic collect(input int cycles);
        got.delete();
        pf_ready = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            if (pf_valid) got.push_back(pf_addr);
            tick();
        end
        pf_ready = 1'b0;
    endtask

    task automatic t_lookahead();
        push(2, 32'ha000, 32'ha040, 1'b1);
        push(2, 32'ha080, 32'ha0c0, 1'b1);
        chk("R9 first candidate valid", 32'(pf_valid), 32'd1);
        chk("R9 first candidate", pf_addr, 32'ha040);
        collect(5);
        chk("R9 issue count", 32'(got.size()), 32'd3);
        for (int k = 0; k < 3 && k < got.size(); k++) chk("R9 issue order", got[k], model[k+1]);
        chk("R9 done", 32'(pf_valid), 32'd0);
        pop_one("R4 pop");
        pop_one("R4 pop");
        pf_ready = 1'b1;
        #1;
        chk("R9 issued once", 32'(pf_valid), 32'd0);
        pf_ready = 1'b0;
        do_flush();
    endtask

    task automatic t_filter();
        push(2, 32'hb000, 32'hb100, 1'b1);
        push(2, 32'hb100, 32'hb200, 1'b1);
        collect(6);
        chk("R10 issue count", 32'(got.size()), 32'd2);
        if (got.size() >= 2) begin
            chk("R10 first", got[0], 32'hb100);
            chk("R10 second", got[1], 32'hb200);
        end
        do_flush();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        t_reset();
        t_order();
        t_miss();
        t_full();
        t_push_pop();
        t_no_bypass();
        t_flush_prio();
        t_lookahead();
        t_filter();
        finish_run();
    end

endmodule